// File: doc/BRIEF.md
# TLB Maintenance Register Port

This block is the software-visible side of a translation lookaside buffer. It owns the buffer's storage: a 32-bit tag word, a 64-bit data word and an 8-bit owner identifier per entry. Software reaches that storage through six numbered registers on a small register bus. The registers are an address-space identifier (ASID), a zone-protection word, an entry index, the selected entry's data word, the selected entry's tag word, and a probe register.

Reads and writes of the data and tag registers act on the entry chosen by the index register. Some accesses have side effects. Writing the tag register records the current ASID as the entry's owner. Reading the tag register reloads the ASID from that owner field. Writing the probe register sends a one-cycle search request to an external translator. The translator's answer then updates the index register.

Two configuration inputs gate the accesses: an MMU level and an access level. All storage is brought out flat, so that the translator can read it. An access is accepted in a cycle where `reg_valid` and `reg_ready` are both high. Read data is returned with `reg_rvalid` one cycle after acceptance.

Top module: `mmu_sreg_port`

## Requirements
- R1: After reset all storage and registers are zero, `reg_ready` is high, and `reg_rvalid`, `reg_err` and `lk_req` are low. The register numbers are: ASID=0, ZONE=1, INDEX=2, DATA=3, TAG=4, PROBE=5.
- R2: The low log2(ENTRIES) bits of INDEX select the entry for DATA and TAG accesses. A DATA access with `reg_ext`=0 reads or writes bits 31:0 of the data word, and with `reg_ext`=1 it reads or writes bits 63:32. Read data appears on `reg_rdata` with `reg_rvalid` one cycle after acceptance.
- R3: A write to INDEX loads bits 30:0 from the write data. Bit 31 (the miss flag) keeps its value.
- R4: Reading TAG returns the selected tag word. The same read loads ASID with that entry's stored owner byte, zero-extended.
- R5: Writing TAG stores the write data as the selected tag word. The same write stores ASID bits 7:0 as that entry's owner byte.
- R6: With `reg_ext`=1, an access to any register other than DATA reads 0 and leaves all state unchanged.
- R7: An accepted write to PROBE drives `lk_vpn` = write data with bits 9:0 cleared and `lk_user` = `priv_user`. If `lk_hit` is high during the request, INDEX becomes `lk_idx` zero-extended, which clears the miss flag. If `lk_hit` is low, INDEX bit 31 is set and bits 30:0 keep their values.
- R8: PROBE always reads 0. INDEX can be read whenever the block is enabled.
- R9: Reads of ASID, ZONE, DATA and TAG need `cfg_access` bit 0 set. Writes of ASID, ZONE and PROBE need `cfg_access` ≥ 2. A read that is refused returns 0, and a write that is refused has no effect.
- R10: When `cfg_level` < 2 or `cfg_access` = 0, every read returns 0 and every write is ignored.
- R11: Register numbers 6 and 7 read 0 and ignore writes. They pulse `reg_err` for one cycle, one cycle after acceptance.
- R12: `lk_req` is high for exactly the one cycle after a probe write is accepted, and `reg_ready` is low in that cycle. An access presented in that cycle is held off and is accepted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 2 | MMU configuration level |
| cfg_access | input | 2 | Register access level |
| priv_user | input | 1 | Current privilege is user, used by probes |
| reg_valid | input | 1 | Access request |
| reg_ready | output | 1 | Low while a probe is outstanding |
| reg_num | input | 3 | Register number |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_ext | input | 1 | Extended (upper half) access |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Unknown register number pulse |
| lk_req | output | 1 | Search request to the translator |
| lk_vpn | output | 32 | Page-number bits to search |
| lk_user | output | 1 | Privilege for the search |
| lk_hit | input | 1 | Search hit, sampled while `lk_req` is high |
| lk_idx | input | log2(ENTRIES) | Matching entry index |
| cur_asid | output | 8 | Current ASID byte |
| zone_prot | output | 32 | Zone-protection word |
| tag_flat | output | ENTRIES*32 | All tag words |
| data_flat | output | ENTRIES*64 | All data words |
| tid_flat | output | ENTRIES*8 | All owner bytes |

## Verification
The assertions assume that `lk_hit` and `lk_idx` are meaningful only in a cycle where `lk_req` is high. They also assume that the configuration inputs stay stable while an access is being accepted. The bench changes the configuration only between accesses, at the falling clock edge. It drives the translator response only in the single request cycle and returns `lk_hit` to low afterwards. The probe-result properties therefore see a clean one-cycle handshake.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    typedef enum logic [2:0] {
        SR_ASID  = 3'd0,
        SR_ZONE  = 3'd1,
        SR_INDEX = 3'd2,
        SR_DATA  = 3'd3,
        SR_TAG   = 3'd4,
        SR_PROBE = 3'd5
    } sreg_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic unknown;
    } dec_t;

    typedef struct packed {
        logic [31:0] asid;
        logic [31:0] zone;
        logic [31:0] index;
        logic [31:0] rdata;
        logic [31:0] probe_vpn;
        logic        probe_user;
        logic        busy;
        logic        rvalid;
        logic        err;
    } port_st_t;

endpackage

// File: rtl/mmu_sreg_decode.sv
module mmu_sreg_decode
    import mmu_sreg_pkg::*;
(
    input  logic [2:0] num,
    input  logic       ext,
    input  logic [1:0] cfg_level,
    input  logic [1:0] cfg_access,
    output dec_t       dec
);
    logic enabled;
    logic ext_bad;
    logic rd_lvl;
    logic wr_lvl;

    always_comb begin
        enabled = (cfg_level >= 2'd2) && (cfg_access != 2'd0);
        ext_bad = ext && (num != SR_DATA);
        rd_lvl  = cfg_access[0];
        wr_lvl  = cfg_access >= 2'd2;
        dec     = '0;
        dec.unknown = num > SR_PROBE;
        if (enabled && !ext_bad) begin
            unique case (num)
                SR_ASID, SR_ZONE: begin
                    dec.rd_ok = rd_lvl;
                    dec.wr_ok = wr_lvl;
                end
                SR_INDEX: begin
                    dec.rd_ok = 1'b1;
                    dec.wr_ok = 1'b1;
                end
                SR_DATA, SR_TAG: begin
                    dec.rd_ok = rd_lvl;
                    dec.wr_ok = 1'b1;
                end
                SR_PROBE: begin
                    dec.rd_ok = 1'b0;
                    dec.wr_ok = wr_lvl;
                end
                default: begin
                    dec.rd_ok = 1'b0;
                    dec.wr_ok = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mmu_sreg_store.sv
module mmu_sreg_store #(
    parameter int ENTRIES = 8,
    parameter int IW      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_data_en,
    input  logic                  wr_tag_en,
    input  logic                  wr_upper,
    input  logic [IW-1:0]         sel,
    input  logic [31:0]           wdata,
    input  logic [7:0]            tid_in,
    output logic [31:0]           rd_tag,
    output logic [63:0]           rd_data,
    output logic [7:0]            rd_tid,
    output logic [ENTRIES*32-1:0] tag_flat,
    output logic [ENTRIES*64-1:0] data_flat,
    output logic [ENTRIES*8-1:0]  tid_flat
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [31:0] tag_d, tag_q;
        logic [63:0] dat_d, dat_q;
        logic [7:0]  tid_d, tid_q;
        logic        hit_sel;

        always_comb begin
            hit_sel = (sel == IW'(e));
            tag_d   = tag_q;
            dat_d   = dat_q;
            tid_d   = tid_q;
            if (wr_tag_en && hit_sel) begin
                tag_d = wdata;
                tid_d = tid_in;
            end
            if (wr_data_en && hit_sel) begin
                if (wr_upper) dat_d[63:32] = wdata;
                else          dat_d[31:0]  = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                dat_q <= '0;
                tid_q <= '0;
            end else begin
                tag_q <= tag_d;
                dat_q <= dat_d;
                tid_q <= tid_d;
            end
        end

        assign tag_flat[e*32 +: 32] = tag_q;
        assign data_flat[e*64 +: 64] = dat_q;
        assign tid_flat[e*8 +: 8]    = tid_q;
    end

    assign rd_tag  = tag_flat[sel*32 +: 32];
    assign rd_data = data_flat[sel*64 +: 64];
    assign rd_tid  = tid_flat[sel*8 +: 8];
endmodule

// File: rtl/mmu_sreg_port.sv
module mmu_sreg_port
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int PAGE_LSB = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_level,
    input  logic [1:0]                 cfg_access,
    input  logic                       priv_user,
    input  logic                       reg_valid,
    output logic                       reg_ready,
    input  logic [2:0]                 reg_num,
    input  logic                       reg_write,
    input  logic                       reg_ext,
    input  logic [31:0]                reg_wdata,
    output logic                       reg_rvalid,
    output logic [31:0]                reg_rdata,
    output logic                       reg_err,
    output logic                       lk_req,
    output logic [31:0]                lk_vpn,
    output logic                       lk_user,
    input  logic                       lk_hit,
    input  logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic [7:0]                 cur_asid,
    output logic [31:0]                zone_prot,
    output logic [ENTRIES*32-1:0]      tag_flat,
    output logic [ENTRIES*64-1:0]      data_flat,
    output logic [ENTRIES*8-1:0]       tid_flat
);
    localparam int          IW       = $clog2(ENTRIES);
    localparam logic [31:0] VPN_MASK = ~((32'd1 << PAGE_LSB) - 32'd1);

    port_st_t    q, d;
    dec_t        dec;
    logic        accept;
    logic        wr_data_en, wr_tag_en;
    logic [31:0] rd_tag;
    logic [63:0] rd_data;
    logic [7:0]  rd_tid;
    logic [31:0] index_q;

    mmu_sreg_decode u_dec (
        .num        (reg_num),
        .ext        (reg_ext),
        .cfg_level  (cfg_level),
        .cfg_access (cfg_access),
        .dec        (dec)
    );

    mmu_sreg_store #(.ENTRIES(ENTRIES), .IW(IW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_tag_en  (wr_tag_en),
        .wr_upper   (reg_ext),
        .sel        (q.index[IW-1:0]),
        .wdata      (reg_wdata),
        .tid_in     (q.asid[7:0]),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data),
        .rd_tid     (rd_tid),
        .tag_flat   (tag_flat),
        .data_flat  (data_flat),
        .tid_flat   (tid_flat)
    );

    always_comb begin
        d          = q;
        d.rvalid   = 1'b0;
        d.err      = 1'b0;
        accept     = reg_valid && !q.busy;
        wr_data_en = accept && reg_write && dec.wr_ok && (reg_num == SR_DATA);
        wr_tag_en  = accept && reg_write && dec.wr_ok && (reg_num == SR_TAG);

        // probe response, taken in the single request cycle
        if (q.busy) begin
            d.busy = 1'b0;
            if (lk_hit) d.index = 32'(lk_idx);
            else        d.index[31] = 1'b1;
        end

        if (accept) begin
            d.err = dec.unknown;
            if (!reg_write) begin
                d.rvalid = 1'b1;
                d.rdata  = '0;
                if (dec.rd_ok) begin
                    unique case (reg_num)
                        SR_ASID:  d.rdata = q.asid;
                        SR_ZONE:  d.rdata = q.zone;
                        SR_INDEX: d.rdata = q.index;
                        SR_DATA:  d.rdata = reg_ext ? rd_data[63:32] : rd_data[31:0];
                        SR_TAG: begin
                            d.rdata = rd_tag;
                            d.asid  = {24'd0, rd_tid};
                        end
                        default:  d.rdata = '0;
                    endcase
                end
            end else if (dec.wr_ok) begin
                unique case (reg_num)
                    SR_ASID:  d.asid  = reg_wdata;
                    SR_ZONE:  d.zone  = reg_wdata;
                    SR_INDEX: d.index = {q.index[31], reg_wdata[30:0]};
                    SR_PROBE: begin
                        d.busy       = 1'b1;
                        d.probe_vpn  = reg_wdata & VPN_MASK;
                        d.probe_user = priv_user;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign index_q    = q.index;
    assign reg_ready  = !q.busy;
    assign reg_rvalid = q.rvalid;
    assign reg_rdata  = q.rdata;
    assign reg_err    = q.err;
    assign lk_req     = q.busy;
    assign lk_vpn     = q.probe_vpn;
    assign lk_user    = q.probe_user;
    assign cur_asid   = q.asid[7:0];
    assign zone_prot  = q.zone;
endmodule

// File: rtl/mmu_sreg_chk.sv
module mmu_sreg_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_level,
    input logic [1:0]    cfg_access,
    input logic          reg_valid,
    input logic          reg_ready,
    input logic [2:0]    reg_num,
    input logic          reg_write,
    input logic          reg_ext,
    input logic          reg_rvalid,
    input logic [31:0]   reg_rdata,
    input logic          reg_err,
    input logic          lk_req,
    input logic          lk_hit,
    input logic [IW-1:0] lk_idx,
    input logic [31:0]   index_q
);
    logic acc;
    assign acc = reg_valid && reg_ready;

    a_r12_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> !lk_req);
    a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !reg_ready);
    a_r12_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> !reg_rvalid);
    a_r7_probe_start: assert property (@(posedge clk) disable iff (!rst_n)
        acc && reg_write && reg_num == 3'd5 && !reg_ext &&
        cfg_level >= 2'd2 && cfg_access >= 2'd2 |=> lk_req);
    a_r7_hit_index: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_hit |=> index_q == 32'($past(lk_idx)));
    a_r7_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_hit |=> index_q[31] && index_q[30:0] == $past(index_q[30:0]));
    a_r3_msb_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acc && reg_write && reg_num == 3'd2 |=> index_q[31] == $past(index_q[31]));
    a_r11_err_on_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        acc && reg_num >= 3'd6 |=> reg_err);
    a_r11_err_only_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && reg_num >= 3'd6) |=> !reg_err);
    a_r10_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !reg_write && (cfg_level < 2'd2 || cfg_access == 2'd0)
        |=> reg_rvalid && reg_rdata == 32'd0);
    a_r8_probe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !reg_write && reg_num == 3'd5 |=> reg_rdata == 32'd0);
endmodule

bind mmu_sreg_port mmu_sreg_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_level  (cfg_level),
    .cfg_access (cfg_access),
    .reg_valid  (reg_valid),
    .reg_ready  (reg_ready),
    .reg_num    (reg_num),
    .reg_write  (reg_write),
    .reg_ext    (reg_ext),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .lk_req     (lk_req),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .index_q    (index_q)
);

// File: tb/mmu_sreg_port_tb.sv
module mmu_sreg_port_tb_top;
    localparam int N = 8;
    localparam logic [2:0] RA = 3'd0, RZ = 3'd1, RI = 3'd2, RD = 3'd3, RT = 3'd4, RP = 3'd5;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] cfg_level = 2'd2, cfg_access = 2'd3;
    logic priv_user = 0;
    logic reg_valid = 0, reg_write = 0, reg_ext = 0;
    logic [2:0] reg_num = '0;
    logic [31:0] reg_wdata = '0;
    logic reg_ready, reg_rvalid, reg_err, lk_req, lk_user;
    logic [31:0] reg_rdata, lk_vpn, zone_prot;
    logic lk_hit = 0;
    logic [2:0] lk_idx = '0;
    logic [7:0] cur_asid;
    logic [N*32-1:0] tag_flat;
    logic [N*64-1:0] data_flat;
    logic [N*8-1:0] tid_flat;

    int checks = 0, errors = 0;
    logic [31:0] m_tag [N], m_lo [N], m_hi [N];
    logic [7:0]  m_tid [N];
    logic [31:0] m_asid = 0, m_zone = 0, m_index = 0;
    logic [31:0] rd;
    logic rv, er;

    always #4 clk = ~clk;

    mmu_sreg_port #(.ENTRIES(N), .PAGE_LSB(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_access(cfg_access),
        .priv_user(priv_user), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_num(reg_num), .reg_write(reg_write), .reg_ext(reg_ext),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .cur_asid(cur_asid), .zone_prot(zone_prot),
        .tag_flat(tag_flat), .data_flat(data_flat), .tid_flat(tid_flat));

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ck(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    // one access, called at a falling edge, returns at the falling edge after acceptance
    task automatic access(input logic [2:0] n, input logic w, input logic e, input logic [31:0] wd);
        while (!reg_ready) @(negedge clk);
        reg_valid = 1; reg_num = n; reg_write = w; reg_ext = e; reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 0; reg_write = 0; reg_ext = 0;
        rd = reg_rdata; rv = reg_rvalid; er = reg_err;
    endtask

    function automatic logic [31:0] exp_rd(input int n, input int e, input int lv, input int ac);
        int ix = int'(m_index[2:0]);
        logic r0 = (ac % 2) == 1;
        if (lv < 2 || ac == 0) return 0;
        if (e != 0 && n != 3) return 0;
        case (n)
            0: return r0 ? m_asid : 32'd0;
            1: return r0 ? m_zone : 32'd0;
            2: return m_index;
            3: return r0 ? (e != 0 ? m_hi[ix] : m_lo[ix]) : 32'd0;
            4: return r0 ? m_tag[ix] : 32'd0;
            default: return 0;
        endcase
    endfunction

    task automatic probe(input logic [31:0] wd, input logic hit, input logic [2:0] idx);
        access(RP, 1, 0, wd);
        ck("R12 req", {63'd0, lk_req}, 64'd1);
        ck("R7 vpn", {32'd0, lk_vpn}, {32'd0, wd & 32'hFFFF_FC00});
        ck("R7 user", {63'd0, lk_user}, {63'd0, priv_user});
        ck("R12 ready low", {63'd0, reg_ready}, 64'd0);
        lk_hit = hit; lk_idx = idx;
        @(posedge clk);
        @(negedge clk);
        lk_hit = 0;
        if (hit) m_index = {29'd0, idx};
        else     m_index[31] = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        ck("R1 ready", {63'd0, reg_ready}, 64'd1);
        ck("R1 rvalid", {63'd0, reg_rvalid}, 64'd0);
        ck("R1 req", {63'd0, lk_req}, 64'd0);
        ck("R1 err", {63'd0, reg_err}, 64'd0);
        ck("R1 tags", {32'd0, tag_flat[31:0] | tag_flat[N*32-1 -: 32]}, 64'd0);
        access(RI, 0, 0, 0);
        ck("R1 index", {32'd0, rd}, 64'd0);

        // fill all entries: R2 R5
        for (int i = 0; i < N; i++) begin
            m_index = i; access(RI, 1, 0, m_index);
            m_asid = 32'h300 + i * 7; access(RA, 1, 0, m_asid);
            m_tag[i] = 32'hC000_0040 | (i << 12); access(RT, 1, 0, m_tag[i]);
            m_tid[i] = m_asid[7:0];
            m_lo[i] = (i * 32'h0101_0101) ^ 32'h1234_0000; access(RD, 1, 0, m_lo[i]);
            m_hi[i] = ~m_lo[i]; access(RD, 1, 1, m_hi[i]);
        end
        for (int i = 0; i < N; i++) begin
            ck("R5 tag store", {32'd0, tag_flat[i*32 +: 32]}, {32'd0, m_tag[i]});
            ck("R5 tid store", {56'd0, tid_flat[i*8 +: 8]}, {56'd0, m_tid[i]});
            ck("R2 data store", data_flat[i*64 +: 64], {m_hi[i], m_lo[i]});
        end
        // read back: R2 R4
        for (int i = 0; i < N; i++) begin
            m_index = i; access(RI, 1, 0, m_index);
            access(RA, 1, 0, 32'hFF);
            access(RT, 0, 0, 0);
            ck("R4 tag read", {32'd0, rd}, {32'd0, m_tag[i]});
            ck("R2 rvalid", {63'd0, rv}, 64'd1);
            access(RA, 0, 0, 0);
            ck("R4 asid reload", {32'd0, rd}, {56'd0, m_tid[i]});
            m_asid = {24'd0, m_tid[i]};
            access(RD, 0, 0, 0);
            ck("R2 data lo", {32'd0, rd}, {32'd0, m_lo[i]});
            access(RD, 0, 1, 0);
            ck("R2 data hi", {32'd0, rd}, {32'd0, m_hi[i]});
        end

        // R6 extended access to non-data registers
        m_index = 1; access(RI, 1, 0, 1);
        access(RT, 1, 1, 32'hDEAD_0000);
        access(RT, 0, 0, 0);
        ck("R6 tag ext write ignored", {32'd0, rd}, {32'd0, m_tag[1]});
        m_asid = {24'd0, m_tid[1]};
        access(RA, 1, 1, 32'h77);
        access(RA, 0, 0, 0);
        ck("R6 asid ext write ignored", {32'd0, rd}, {32'd0, m_asid});
        access(RA, 0, 1, 0);
        ck("R6 asid ext read zero", {32'd0, rd}, 64'd0);

        m_zone = 32'h5555_AAAA; access(RZ, 1, 0, m_zone);
        ck("R9 zone out", {32'd0, zone_prot}, {32'd0, m_zone});
        m_index = 2; access(RI, 1, 0, 2);

        // read permission sweep: R8 R9 R10 R11
        for (int lv = 0; lv < 4; lv++)
            for (int ac = 0; ac < 4; ac++)
                for (int n = 0; n < 8; n++)
                    for (int e = 0; e < 2; e++) begin
                        logic [31:0] ex;
                        @(negedge clk);
                        cfg_level = lv[1:0]; cfg_access = ac[1:0];
                        ex = exp_rd(n, e, lv, ac);
                        access(n[2:0], 0, e[0], 0);
                        chk(rd == ex, "R9 R10 R8 read gate", {32'd0, rd}, {32'd0, ex});
                        chk(er == (n >= 6), "R11 err pulse", {63'd0, er}, {63'd0, n >= 6});
                        if (n == 4 && e == 0 && lv >= 2 && ac % 2 == 1)
                            m_asid = {24'd0, m_tid[2]};
                    end

        // write permission sweep: R9 R10 R11
        for (int lv = 0; lv < 4; lv++)
            for (int ac = 0; ac < 4; ac++) begin
                logic on, hi;
                on = (lv >= 2) && (ac != 0);
                hi = on && (ac >= 2);
                cfg_level = lv[1:0]; cfg_access = ac[1:0];
                access(RA, 1, 0, 32'h1000 + lv * 4 + ac);
                if (hi) m_asid = 32'h1000 + lv * 4 + ac;
                access(RZ, 1, 0, 32'h2000 + lv * 4 + ac);
                if (hi) m_zone = 32'h2000 + lv * 4 + ac;
                access(RI, 1, 0, 32'h40 + lv * 4 + ac);
                if (on) m_index = {m_index[31], 31'h40 + 31'(lv * 4 + ac)};
                access(3'd6, 1, 0, 32'hFFFF_FFFF);
                ck("R11 err on write", {63'd0, er}, 64'd1);
                access(RP, 1, 0, 32'h0);
                ck("R9 probe gate", {63'd0, lk_req}, {63'd0, hi});
                if (lk_req) begin
                    @(posedge clk); @(negedge clk);
                    m_index[31] = 1'b1;
                end
                cfg_level = 2; cfg_access = 3;
                access(RA, 0, 0, 0); ck("R9 R10 asid write gate", {32'd0, rd}, {32'd0, m_asid});
                access(RZ, 0, 0, 0); ck("R9 R10 zone write gate", {32'd0, rd}, {32'd0, m_zone});
                access(RI, 0, 0, 0); ck("R10 index write gate", {32'd0, rd}, {32'd0, m_index});
            end

        // probes: R7 R12 R3
        m_index = 0; access(RI, 1, 0, 0);
        access(RI, 0, 0, 0);
        priv_user = 1;
        access(RP, 1, 0, 32'hDEAD_BEEF);
        ck("R7 vpn mask", {32'd0, lk_vpn}, 64'hDEAD_BC00);
        ck("R7 user", {63'd0, lk_user}, 64'd1);
        ck("R12 ready low", {63'd0, reg_ready}, 64'd0);
        lk_hit = 1; lk_idx = 3'd5;
        reg_valid = 1; reg_num = RI; reg_write = 0;
        @(posedge clk); @(negedge clk);
        lk_hit = 0;
        ck("R12 stalled", {63'd0, reg_rvalid}, 64'd0);
        ck("R12 req one cycle", {63'd0, lk_req}, 64'd0);
        @(posedge clk); @(negedge clk);
        reg_valid = 0;
        ck("R12 accepted after", {63'd0, reg_rvalid}, 64'd1);
        ck("R7 hit index", {32'd0, reg_rdata}, 64'd5);
        priv_user = 0;
        m_index = 32'h0000_0003; access(RI, 1, 0, 32'h8000_0003);
        access(RI, 0, 0, 0); ck("R3 msb not writable", {32'd0, rd}, 64'h3);
        probe(32'h0001_2345, 0, 3'd0);
        access(RI, 0, 0, 0); ck("R7 miss flag", {32'd0, rd}, 64'h8000_0003);
        access(RI, 1, 0, 32'h0000_0001);
        access(RI, 0, 0, 0); ck("R3 msb kept", {32'd0, rd}, 64'h8000_0001);
        probe(32'hFFFF_FFFF, 1, 3'd6);
        access(RI, 0, 0, 0); ck("R7 hit clears flag", {32'd0, rd}, 64'h6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule